// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a processor's load/store stage and a 32-bit data memory. It is purely combinational. For a store it turns the effective byte address, the access size and the source register value into a word-aligned memory address, a four-bit byte-enable mask and a write word. In that write word the byte or halfword is copied into every lane where it could land. For a load it picks the addressed byte, halfword or word out of the returned memory word. It then widens the value to 32 bits, with sign or zero extension chosen by a flag.

Byte lanes follow little-endian order: the byte at offset 0 of a word sits in bits 7:0. Accesses that do not fall on their natural boundary are not split into two transfers. The block detects them, raises a flag and suppresses every byte enable, so the memory is never written. The load result is also forced to zero for such accesses. The same address and size inputs serve both directions. The memory's own write strobe decides whether the enables are used.

Top module: `lsu_lane_aligner`

## Requirements
- R1: `mem_addr` equals `eff_addr` with its two low bits forced to zero.
- R2: For size code 2'b00 (byte), `mem_be` has exactly one bit set, bit number `eff_addr[1:0]`.
- R3: For size code 2'b01 (halfword) with `eff_addr[0]`=0, `mem_be` is 4'b0011 when `eff_addr[1]`=0 and 4'b1100 when `eff_addr[1]`=1.
- R4: For size code 2'b10 (word) with `eff_addr[1:0]`=0, `mem_be` is 4'b1111.
- R5: `mem_wdata` holds `st_data[7:0]` in all four lanes for size 2'b00. It holds `st_data[15:0]` in both halves for size 2'b01. For sizes 2'b10 and 2'b11 it equals `st_data` unchanged. This holds whatever the address.
- R6: `misaligned` is 1 for a halfword with `eff_addr[0]`=1, for a word with `eff_addr[1:0]`≠0, and for the reserved size code 2'b11. While it is 1, `mem_be` is 4'b0000. A byte access never raises it.
- R7: A byte load returns `mem_rdata[8*off+7:8*off]`, where off=`eff_addr[1:0]`. It is sign-extended when `ld_unsigned`=0 and zero-extended when `ld_unsigned`=1.
- R8: An aligned halfword load returns `mem_rdata[31:16]` when `eff_addr[1]`=1 and `mem_rdata[15:0]` otherwise. It is sign- or zero-extended as in R7.
- R9: An aligned word load returns `mem_rdata` unchanged, and `ld_unsigned` has no effect on it.
- R10: While `misaligned` is 1, `ld_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| eff_addr | input | ADDR_W (32) | Effective byte address of the access |
| acc_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| ld_unsigned | input | 1 | 1 selects zero extension for byte and halfword loads |
| st_data | input | 32 | Register value to be stored |
| mem_rdata | input | 32 | Word returned by the data memory for a load |
| mem_addr | output | ADDR_W (32) | Word-aligned address presented to the memory |
| mem_be | output | 4 | Byte-lane write enables, bit n enables bits 8n+7:8n |
| mem_wdata | output | 32 | Store data placed in its byte lanes |
| ld_data | output | 32 | Extracted and extended load result |
| misaligned | output | 1 | Access does not sit on its natural boundary, or size is reserved |

## Verification
The bench builds the block with its default 32-bit address. It crosses all four size codes, all four low-address offsets and both extension settings. This covers every lane choice, every misalignment case and the reserved code. The data words are chosen so that every lane appears with its top bit both set and clear, which exposes sign extension taken from the wrong bit. Varied upper address bits show that only the two low bits are cleared.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  localparam int XLEN   = 32;
  localparam int NBYTES = XLEN / 8;
  localparam int OFF_W  = $clog2(NBYTES);

  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_RSVD = 2'b11
  } acc_size_e;

endpackage

// File: rtl/access_align_check.sv
module access_align_check
  import lsu_align_pkg::*;
(
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             misaligned_o
);

  always_comb begin
    case (size_i)
      ACC_BYTE: misaligned_o = 1'b0;
      ACC_HALF: misaligned_o = off_i[0];
      ACC_WORD: misaligned_o = |off_i;
      default:  misaligned_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/lane_store_pack.sv
module lane_store_pack
  import lsu_align_pkg::*;
(
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [XLEN-1:0]   data_i,
  output logic [NBYTES-1:0] be_o,
  output logic [XLEN-1:0]   wdata_o
);

  // Raw lane enables, before any misalignment squash.
  always_comb begin
    logic [NBYTES-1:0] be_v;
    for (int lane = 0; lane < NBYTES; lane++) begin
      case (size_i)
        ACC_BYTE: be_v[lane] = (OFF_W'(lane) == off_i);
        ACC_HALF: be_v[lane] = ((OFF_W'(lane) >> 1) == (off_i >> 1));
        ACC_WORD: be_v[lane] = 1'b1;
        default:  be_v[lane] = 1'b0;
      endcase
    end
    be_o = be_v;

    if (!$isunknown(size_i) && !$isunknown(off_i)) begin
      if (size_i == ACC_BYTE) begin
        assert_byte_one_lane_R2: assert ($countones(be_v) == 1 && be_v[off_i])
          else $error("byte access must enable exactly the addressed lane");
      end
      if (size_i == ACC_HALF) begin
        assert_half_two_lanes_R3: assert ($countones(be_v) == 2 && be_v[{off_i[OFF_W-1:1], 1'b0}])
          else $error("halfword access must enable one aligned lane pair");
      end
      if (size_i == ACC_WORD) begin
        assert_word_all_lanes_R4: assert ($countones(be_v) == NBYTES)
          else $error("word access must enable every lane");
      end
    end
  end

  // Lane replication: each lane takes the source byte it would hold
  // if the access were aimed at it.
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    localparam int HALF_SRC = g % 2;
    logic [7:0] lane_byte;
    assign lane_byte = (size_i == ACC_BYTE) ? data_i[7:0] :
                       (size_i == ACC_HALF) ? data_i[8*HALF_SRC +: 8] :
                                              data_i[8*g +: 8];
    assign wdata_o[8*g +: 8] = lane_byte;
  end

endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
  import lsu_align_pkg::*;
(
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             unsigned_i,
  input  logic [XLEN-1:0]  rdata_i,
  output logic [XLEN-1:0]  value_o
);

  always_comb begin
    logic [7:0]      byte_v;
    logic [15:0]     half_v;
    logic            fill_b;
    logic            fill_h;
    logic [XLEN-1:0] val_v;

    byte_v = rdata_i[{off_i, 3'b000} +: 8];
    half_v = rdata_i[{off_i[OFF_W-1:1], 4'b0000} +: 16];
    fill_b = ~unsigned_i & byte_v[7];
    fill_h = ~unsigned_i & half_v[15];

    case (size_i)
      ACC_BYTE: val_v = {{(XLEN-8){fill_b}}, byte_v};
      ACC_HALF: val_v = {{(XLEN-16){fill_h}}, half_v};
      ACC_WORD: val_v = rdata_i;
      default:  val_v = '0;
    endcase
    value_o = val_v;

    if (!$isunknown(size_i) && !$isunknown(unsigned_i) && !$isunknown(val_v)) begin
      if (size_i == ACC_BYTE && !unsigned_i) begin
        assert_byte_sext_R7: assert (val_v[XLEN-1:8] == {(XLEN-8){val_v[7]}})
          else $error("signed byte load upper bits must copy bit 7");
      end
      if (size_i == ACC_BYTE && unsigned_i) begin
        assert_byte_zext_R7: assert (val_v[XLEN-1:8] == '0)
          else $error("unsigned byte load upper bits must be zero");
      end
      if (size_i == ACC_HALF) begin
        assert_half_ext_R8: assert (unsigned_i ? (val_v[XLEN-1:16] == '0)
                                               : (val_v[XLEN-1:16] == {(XLEN-16){val_v[15]}}))
          else $error("halfword load extension wrong");
      end
    end
  end

endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [1:0]        acc_size,
  input  logic              ld_unsigned,
  input  logic [XLEN-1:0]   st_data,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NBYTES-1:0] mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  output logic [XLEN-1:0]   ld_data,
  output logic              misaligned
);

  acc_size_e         size_e;
  logic [OFF_W-1:0]  off;
  logic [NBYTES-1:0] raw_be;
  logic [XLEN-1:0]   ext_val;
  logic              mis_w;

  assign size_e = acc_size_e'(acc_size);
  assign off    = eff_addr[OFF_W-1:0];

  access_align_check u_check (
    .size_i       (size_e),
    .off_i        (off),
    .misaligned_o (mis_w)
  );

  lane_store_pack u_store (
    .size_i  (size_e),
    .off_i   (off),
    .data_i  (st_data),
    .be_o    (raw_be),
    .wdata_o (mem_wdata)
  );

  lane_load_extract u_load (
    .size_i     (size_e),
    .off_i      (off),
    .unsigned_i (ld_unsigned),
    .rdata_i    (mem_rdata),
    .value_o    (ext_val)
  );

  always_comb begin
    logic bad_v;
    mem_addr   = {eff_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    misaligned = mis_w;
    mem_be     = mis_w ? '0 : raw_be;
    ld_data    = mis_w ? '0 : ext_val;

    // Independent decode of the boundary rule, checked against the
    // alignment unit and the gated enables.
    bad_v = (acc_size == 2'b01 && eff_addr[0]) ||
            (acc_size == 2'b10 && eff_addr[1:0] != 2'b00) ||
            (acc_size == 2'b11);
    if (!$isunknown(acc_size) && !$isunknown(eff_addr[1:0])) begin
      assert_misalign_squash_R6: assert (bad_v == mis_w && (!bad_v || mem_be == '0))
        else $error("misaligned access must flag and drop every enable");
    end
  end

endmodule

// File: tb/lsu_lane_aligner_bench.sv
module lsu_lane_aligner_bench;

  logic        clk;
  logic        rst_n;
  logic [31:0] eff_addr;
  logic [1:0]  acc_size;
  logic        ld_unsigned;
  logic [31:0] st_data;
  logic [31:0] mem_rdata;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] ld_data;
  logic        misaligned;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 0;

  lsu_lane_aligner #(.ADDR_W(32)) u_lsu_lane_aligner (
    .eff_addr    (eff_addr),
    .acc_size    (acc_size),
    .ld_unsigned (ld_unsigned),
    .st_data     (st_data),
    .mem_rdata   (mem_rdata),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .mem_wdata   (mem_wdata),
    .ld_data     (ld_data),
    .misaligned  (misaligned)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      finish_run();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%08h expected=%08h (size=%0d addr=%08h uns=%0b)",
               req, act, exp, acc_size, eff_addr, ld_unsigned);
    end
  endtask

  function automatic logic [31:0] pat(int i);
    case (i)
      0: return 32'h80FF7F01;
      1: return 32'h7E8100FE;
      2: return 32'hDEADBEEF;
      3: return 32'h12345678;
      4: return 32'hFFFFFFFF;
      default: return 32'h00000000;
    endcase
  endfunction

  function automatic bit exp_mis(int sz, int off);
    if (sz == 0) return 0;
    if (sz == 1) return (off % 2) != 0;
    if (sz == 2) return off != 0;
    return 1;
  endfunction

  function automatic logic [3:0] exp_be(int sz, int off);
    if (exp_mis(sz, off)) return 4'b0000;
    if (sz == 0) return 4'(1 << off);
    if (sz == 1) return (off >= 2) ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_wdata(int sz, logic [31:0] d);
    if (sz == 0) return {4{d[7:0]}};
    if (sz == 1) return {2{d[15:0]}};
    return d;
  endfunction

  function automatic logic [31:0] exp_load(int sz, int off, bit uns, logic [31:0] r);
    logic [31:0] v;
    if (exp_mis(sz, off)) return 32'h0;
    if (sz == 0) begin
      v = (r >> (8 * off)) & 32'hFF;
      if (!uns && v >= 32'h80) v = v | 32'hFFFFFF00;
      return v;
    end
    if (sz == 1) begin
      v = (r >> (16 * (off / 2))) & 32'hFFFF;
      if (!uns && v >= 32'h8000) v = v | 32'hFFFF0000;
      return v;
    end
    return r;
  endfunction

  initial begin
    rst_n       = 1'b0;
    eff_addr    = 32'h0;
    acc_size    = 2'b00;
    ld_unsigned = 1'b0;
    st_data     = 32'h0;
    mem_rdata   = 32'h0;
    repeat (3) @(posedge clk);
    #1;
    // Reset state with all inputs at zero.
    check("R1 reset addr", mem_addr, 32'h0);
    check("R2 reset be", {28'h0, mem_be}, 32'h1);
    check("R6 reset flag", {31'h0, misaligned}, 32'h0);
    check("R7 reset load", ld_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int p = 0; p < 6; p++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int off = 0; off < 4; off++) begin
          for (int u = 0; u < 2; u++) begin
            @(negedge clk);
            eff_addr    = (pat((p + 2) % 6) & 32'hFFFFFFFC) | 32'(off);
            acc_size    = 2'(sz);
            ld_unsigned = 1'(u);
            st_data     = pat(p);
            mem_rdata   = pat((p + 1) % 6);
            @(posedge clk);
            #1;
            check("R1 word address", mem_addr, eff_addr & 32'hFFFFFFFC);
            check("R6 misaligned flag", {31'h0, misaligned}, {31'h0, exp_mis(sz, off)});
            if (exp_mis(sz, off))
              check("R6 enables dropped", {28'h0, mem_be}, 32'h0);
            else if (sz == 0)
              check("R2 byte enable", {28'h0, mem_be}, {28'h0, exp_be(sz, off)});
            else if (sz == 1)
              check("R3 half enable", {28'h0, mem_be}, {28'h0, exp_be(sz, off)});
            else
              check("R4 word enable", {28'h0, mem_be}, {28'h0, exp_be(sz, off)});
            check("R5 store lanes", mem_wdata, exp_wdata(sz, st_data));
            if (exp_mis(sz, off))
              check("R10 misaligned load zero", ld_data, 32'h0);
            else if (sz == 0)
              check("R7 byte load", ld_data, exp_load(sz, off, u[0], mem_rdata));
            else if (sz == 1)
              check("R8 half load", ld_data, exp_load(sz, off, u[0], mem_rdata));
            else
              check("R9 word load", ld_data, exp_load(sz, off, u[0], mem_rdata));
          end
        end
      end
    end
    finish_run();
  end

endmodule